// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date in packed BCD. A one-cycle enable pulse, `tick`, arrives ten times per second. Each pulse advances a tenths-of-a-second digit. The carries ripple through seconds, minutes, hours, date, month and a two-digit year in the same cycle, and a separate day-of-week counter moves on each new day. The hour field carries its own format bit, so software can run the clock in 24-hour or 12-hour form.

A host reaches the fields through a narrow register port with an 8-bit data path and 3-bit addresses. Writes are honoured only while `timeWrEn` is high. A write also zeroes the tenths digit and stops counting until the host marks the end of its transaction with `hostStop`. At that point counting resumes with the tenths digit at 0, which realigns the one-second phase with the end of the write. Reads come from a snapshot register. A `readStart` pulse loads it, so a burst of reads sees one consistent time even if ticks arrive during the burst.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00 (12-hour form, PM flag 0), date 01, month 01, year 00, day of week 0 and tenths 0.
- R2: The tenths digit counts 0 to 9 on each `tick`. A tick that finds it at 9 sets it to 0 and advances seconds.
- R3: Seconds and minutes count 00 to 59 in BCD. From 59 a carry sets the field to 00 and advances the next field.
- R4: Hour bit 7 set selects 24-hour form, with bits 5:0 holding 00 to 23. From 23 a carry gives 00, keeps bit 7 and starts a new day.
- R5: Hour bit 7 clear selects 12-hour form, with bit 5 as the PM flag and bits 4:0 holding the hour. The hour runs 12, 01, ..., 11. The PM flag flips on 11 to 12, and 11 PM to 12 AM starts a new day.
- R6: Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30. Month 02 has 29 days when the year value is a multiple of 4, year 00 included, and 28 days otherwise.
- R7: Month 12 is followed by month 01 with a year increment, and year 99 is followed by 00. Day of week counts 0 to 6 and wraps to 0 on each new day.
- R8: While `timeWrEn` is low, a `hostWe` has no effect on any field.
- R9: An accepted write zeroes the tenths digit. Data written to the tenths address (7) is discarded.
- R10: From an accepted write until the next `hostStop`, ticks are ignored. After that `hostStop` the tenths digit is 0 and counting continues.
- R11: `hostRdata` shows the field at `hostAddr` as it stood at the latest `readStart`. Ticks after the snapshot do not change it.
- R12: Field addresses are 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week and 7 tenths. Bits with no meaning are stored and read as 0. The hour keeps bits 7 and 5:0, the day of week bits 2:0, the date bits 5:0 and the month bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 10 Hz |
| timeWrEn | input | 1 | Allows writes to the time fields |
| hostWe | input | 1 | Write strobe |
| hostAddr | input | 3 | Field address for both writes and reads |
| hostWdata | input | 8 | Write data |
| hostStop | input | 1 | End of a host transaction |
| readStart | input | 1 | Loads the snapshot from the live time |
| hostRdata | output | 8 | Snapshot field at `hostAddr` |

## Verification
A wrong carry or month-length choice puts a bad value into a live field. It reaches `hostRdata` one cycle after the next `readStart`, and the error stays there because later carries build on it. The bench places the clock just before each rollover boundary and reads all affected fields after the critical tick. A stuck hold or gate flag shows as seconds that do not move, or that move when they should not, within ten ticks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int SUB_LAST = 9;

  localparam logic [ADDR_W-1:0] ADDR_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MIN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOUR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MONTH = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_YEAR  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_DOW   = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_SUB   = 3'd7;

  typedef struct packed {
    logic [3:0] sub;
    logic [6:0] sec;
    logic [6:0] min;
    logic [7:0] hour;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
    logic [2:0] dow;
  } calTime_t;

  typedef struct packed {
    logic              load;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              clrSub;
    logic              advance;
    logic              snap;
  } calStrobe_t;

  // increment of a two-digit packed BCD value
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic yearIsLeap(input logic [7:0] y);
    logic res;
    if (!y[4]) res = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       res = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return res;
  endfunction

  // last date of a month, in BCD
  function automatic logic [5:0] lastDate(input logic [4:0] m, input logic [7:0] y);
    logic [5:0] d;
    case (m)
      5'h02:                      d = yearIsLeap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              timeWrEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostStop,
  input  logic              readStart,
  output calStrobe_t        strobes,
  output logic              writeOpen
);

  logic accept;

  assign accept = hostWe && timeWrEn;

  // open from the first accepted write until the transaction ends
  always_ff @(posedge clk) begin
    if (!rst_n)        writeOpen <= 1'b0;
    else if (accept)   writeOpen <= 1'b1;
    else if (hostStop) writeOpen <= 1'b0;
  end

  always_comb begin
    strobes.load    = accept && (hostAddr != ADDR_SUB);
    strobes.addr    = hostAddr;
    strobes.data    = hostWdata;
    strobes.clrSub  = accept || (hostStop && writeOpen);
    strobes.advance = tick && !writeOpen && !accept;
    strobes.snap    = readStart;
  end

endmodule

// File: rtl/rtc_cal_dp.sv
module rtc_cal_dp
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  calStrobe_t        strobes,
  input  logic [ADDR_W-1:0] rdAddr,
  output calTime_t          curTime,
  output calTime_t          snapTime,
  output logic [DATA_W-1:0] rdData
);

  localparam int N_FIELDS = 1 << ADDR_W;

  calTime_t nextTime;
  calTime_t resetTime;

  logic carrySub, carrySec, carryMin, carryDay, carryDate, carryMon;
  logic [7:0] secInc, minInc, hrInc, dateInc, monInc, yrInc;

  assign resetTime = '{sub: 4'd0, sec: 7'h00, min: 7'h00, hour: 8'h00,
                       date: 6'h01, month: 5'h01, year: 8'h00, dow: 3'd0};

  assign secInc  = bcdInc({1'b0, curTime.sec});
  assign minInc  = bcdInc({1'b0, curTime.min});
  assign hrInc   = bcdInc({3'b000, curTime.hour[4:0]});
  assign dateInc = bcdInc({2'b00, curTime.date});
  assign monInc  = bcdInc({3'b000, curTime.month});
  assign yrInc   = bcdInc(curTime.year);

  // ripple of all carries for one tick
  always_comb begin
    nextTime = curTime;
    carryDay = 1'b0;

    carrySub = (curTime.sub >= 4'(SUB_LAST));
    nextTime.sub = carrySub ? 4'd0 : curTime.sub + 4'd1;

    carrySec = carrySub && (curTime.sec >= 7'h59);
    if (carrySub) nextTime.sec = carrySec ? 7'h00 : secInc[6:0];

    carryMin = carrySec && (curTime.min >= 7'h59);
    if (carrySec) nextTime.min = carryMin ? 7'h00 : minInc[6:0];

    if (carryMin) begin
      if (curTime.hour[7]) begin
        if (curTime.hour[5:0] >= 6'h23) begin
          nextTime.hour = 8'h80;
          carryDay      = 1'b1;
        end else begin
          nextTime.hour = {2'b10, bcdInc({2'b00, curTime.hour[5:0]})[5:0]};
        end
      end else begin
        if (curTime.hour[4:0] == 5'h11) begin
          nextTime.hour = {2'b00, ~curTime.hour[5], 5'h12};
          carryDay      = curTime.hour[5];
        end else if (curTime.hour[4:0] >= 5'h12) begin
          nextTime.hour = {2'b00, curTime.hour[5], 5'h01};
        end else begin
          nextTime.hour = {2'b00, curTime.hour[5], hrInc[4:0]};
        end
      end
    end

    carryDate = carryDay && (curTime.date >= lastDate(curTime.month, curTime.year));
    if (carryDay) nextTime.date = carryDate ? 6'h01 : dateInc[5:0];

    carryMon = carryDate && (curTime.month >= 5'h12);
    if (carryDate) nextTime.month = carryMon ? 5'h01 : monInc[4:0];

    if (carryMon) nextTime.year = (curTime.year >= 8'h99) ? 8'h00 : yrInc;

    if (carryDay) nextTime.dow = (curTime.dow >= 3'd6) ? 3'd0 : curTime.dow + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curTime <= resetTime;
    end else if (strobes.load) begin
      curTime.sub <= 4'd0;
      case (strobes.addr)
        ADDR_SEC:   curTime.sec   <= strobes.data[6:0];
        ADDR_MIN:   curTime.min   <= strobes.data[6:0];
        ADDR_HOUR:  curTime.hour  <= {strobes.data[7], 1'b0, strobes.data[5:0]};
        ADDR_DATE:  curTime.date  <= strobes.data[5:0];
        ADDR_MONTH: curTime.month <= strobes.data[4:0];
        ADDR_YEAR:  curTime.year  <= strobes.data;
        ADDR_DOW:   curTime.dow   <= strobes.data[2:0];
        default:    curTime.sub   <= 4'd0;
      endcase
    end else if (strobes.clrSub) begin
      curTime.sub <= 4'd0;
    end else if (strobes.advance) begin
      curTime <= nextTime;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            snapTime <= resetTime;
    else if (strobes.snap) snapTime <= curTime;
  end

  // read view of the snapshot, one byte per field address
  logic [DATA_W-1:0] fieldView [N_FIELDS];

  generate
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_view
      always_comb begin
        case (ADDR_W'(g))
          ADDR_SEC:   fieldView[g] = {1'b0, snapTime.sec};
          ADDR_MIN:   fieldView[g] = {1'b0, snapTime.min};
          ADDR_HOUR:  fieldView[g] = snapTime.hour;
          ADDR_DATE:  fieldView[g] = {2'b00, snapTime.date};
          ADDR_MONTH: fieldView[g] = {3'b000, snapTime.month};
          ADDR_YEAR:  fieldView[g] = snapTime.year;
          ADDR_DOW:   fieldView[g] = {5'b00000, snapTime.dow};
          default:    fieldView[g] = {4'b0000, snapTime.sub};
        endcase
      end
    end
  endgenerate

  assign rdData = fieldView[rdAddr];

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              timeWrEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostStop,
  input  logic              readStart,
  output logic [DATA_W-1:0] hostRdata
);

  calStrobe_t strobes;
  calTime_t   curTime;
  calTime_t   snapTime;
  logic       writeOpen;

  rtc_cal_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .timeWrEn  (timeWrEn),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostStop  (hostStop),
    .readStart (readStart),
    .strobes   (strobes),
    .writeOpen (writeOpen)
  );

  rtc_cal_dp i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .rdAddr   (hostAddr),
    .curTime  (curTime),
    .snapTime (snapTime),
    .rdData   (hostRdata)
  );

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     tick,
  input logic     timeWrEn,
  input logic     hostWe,
  input logic     hostStop,
  input logic     readStart,
  input logic     writeOpen,
  input calTime_t curTime,
  input calTime_t snapTime
);

  a_r2_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    curTime.sub <= 4'd9);

  a_r3_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (curTime.sec[3:0] <= 4'd9) && (curTime.sec <= 7'h59));

  a_r7_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> curTime.dow <= 3'd6);

  a_r8_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeWrEn && !tick && !(hostStop && writeOpen)) |=> $stable(curTime));

  a_r9_write_clears_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWe && timeWrEn) |=> curTime.sub == 4'd0);

  a_r10_hold_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (writeOpen && !hostWe && !hostStop) |=> $stable(curTime));

  a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !readStart |=> $stable(snapTime));

endmodule

bind rtc_calendar rtc_calendar_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .timeWrEn  (timeWrEn),
  .hostWe    (hostWe),
  .hostStop  (hostStop),
  .readStart (readStart),
  .writeOpen (writeOpen),
  .curTime   (curTime),
  .snapTime  (snapTime)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       timeWrEn = 1'b0;
  logic       hostWe = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic [7:0] hostWdata = 8'h00;
  logic       hostStop = 1'b0;
  logic       readStart = 1'b0;
  logic [7:0] hostRdata;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t expQ[$];

  always #5 clk = ~clk;

  rtc_calendar i_rtc_calendar (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .timeWrEn  (timeWrEn),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostStop  (hostStop),
    .readStart (readStart),
    .hostRdata (hostRdata)
  );

  // monitor: compare one queued expectation per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nChecks++;
      if (hostRdata !== it.exp) begin
        nFail++;
        $display("FAIL %s addr %0d: got %h expected %h", it.tag, it.addr, hostRdata, it.exp);
      end
    end
  end

  task automatic readCheck(input logic [2:0] a, input logic [7:0] e, input string tag);
    hostAddr = a;
    expQ.push_back('{addr: a, exp: e, tag: tag});
    @(negedge clk);
    #1;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    hostWe = 1'b1;
    hostAddr = a;
    hostWdata = d;
    @(posedge clk);
    #1;
    hostWe = 1'b0;
  endtask

  task automatic endXfer();
    hostStop = 1'b1;
    @(posedge clk);
    #1;
    hostStop = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    tick = 1'b0;
  endtask

  task automatic snap();
    readStart = 1'b1;
    @(posedge clk);
    #1;
    readStart = 1'b0;
  endtask

  task automatic setAll(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                        input logic [7:0] w);
    writeReg(3'd0, s);
    writeReg(3'd1, m);
    writeReg(3'd2, h);
    writeReg(3'd3, d);
    writeReg(3'd4, mo);
    writeReg(3'd5, y);
    writeReg(3'd6, w);
    endXfer();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R1 reset state
    snap();
    readCheck(3'd0, 8'h00, "R1 sec");
    readCheck(3'd1, 8'h00, "R1 min");
    readCheck(3'd2, 8'h00, "R1 hour");
    readCheck(3'd3, 8'h01, "R1 date");
    readCheck(3'd4, 8'h01, "R1 month");
    readCheck(3'd5, 8'h00, "R1 year");
    readCheck(3'd6, 8'h00, "R1 dow");
    readCheck(3'd7, 8'h00, "R1 sub");

    // R8 write with gate closed is ignored
    writeReg(3'd0, 8'h30);
    writeReg(3'd3, 8'h15);
    endXfer();
    snap();
    readCheck(3'd0, 8'h00, "R8 sec unchanged");
    readCheck(3'd3, 8'h01, "R8 date unchanged");

    timeWrEn = 1'b1;

    // R2 R3 R4 R7 full rollover, 24-hour form
    setAll(8'h58, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06);
    ticks(7);
    snap();
    readCheck(3'd7, 8'h07, "R2 sub counts");
    readCheck(3'd0, 8'h58, "R2 no carry before 10th");
    ticks(3);
    snap();
    readCheck(3'd7, 8'h00, "R2 sub wraps");
    readCheck(3'd0, 8'h59, "R2 sec advanced");
    ticks(10);
    snap();
    readCheck(3'd0, 8'h00, "R3 sec wrap");
    readCheck(3'd1, 8'h00, "R3 min wrap");
    readCheck(3'd2, 8'h80, "R4 hour 23 to 00");
    readCheck(3'd3, 8'h01, "R6 date 31 to 01");
    readCheck(3'd4, 8'h01, "R7 month 12 to 01");
    readCheck(3'd5, 8'h00, "R7 year 99 to 00");
    readCheck(3'd6, 8'h00, "R7 dow 6 to 0");

    // R9 write clears tenths, tenths address data discarded
    ticks(4);
    writeReg(3'd7, 8'h05);
    endXfer();
    snap();
    readCheck(3'd7, 8'h00, "R9 sub cleared by write");
    ticks(3);
    writeReg(3'd1, 8'h20);
    snap();
    readCheck(3'd7, 8'h00, "R9 sub cleared by field write");
    readCheck(3'd1, 8'h20, "R9 field loaded");

    // R10 ticks ignored while write open, resume after stop
    writeReg(3'd0, 8'h10);
    ticks(15);
    snap();
    readCheck(3'd0, 8'h10, "R10 held during write");
    readCheck(3'd7, 8'h00, "R10 sub held");
    endXfer();
    ticks(10);
    snap();
    readCheck(3'd0, 8'h11, "R10 counts after stop");
    readCheck(3'd7, 8'h00, "R10 phase realigned");

    // R11 snapshot frozen across ticks
    snap();
    ticks(10);
    readCheck(3'd0, 8'h11, "R11 snapshot frozen");
    snap();
    readCheck(3'd0, 8'h12, "R11 new snapshot");

    // R5 12-hour form
    setAll(8'h59, 8'h59, 8'h11, 8'h10, 8'h05, 8'h20, 8'h02);
    ticks(10);
    snap();
    readCheck(3'd2, 8'h32, "R5 11AM to 12PM");
    readCheck(3'd3, 8'h10, "R5 no new day at noon");
    setAll(8'h59, 8'h59, 8'h32, 8'h10, 8'h05, 8'h20, 8'h02);
    ticks(10);
    snap();
    readCheck(3'd2, 8'h21, "R5 12PM to 1PM");
    setAll(8'h59, 8'h59, 8'h31, 8'h10, 8'h05, 8'h20, 8'h02);
    ticks(10);
    snap();
    readCheck(3'd2, 8'h12, "R5 11PM to 12AM");
    readCheck(3'd3, 8'h11, "R5 new day at midnight");
    readCheck(3'd6, 8'h03, "R7 dow increments");

    // R6 month lengths and leap years
    setAll(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h00);
    ticks(10);
    snap();
    readCheck(3'd3, 8'h29, "R6 leap feb 29");
    readCheck(3'd4, 8'h02, "R6 leap still feb");
    setAll(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h00);
    ticks(10);
    snap();
    readCheck(3'd3, 8'h01, "R6 common feb ends at 28");
    readCheck(3'd4, 8'h03, "R6 march follows");
    setAll(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h00, 8'h00);
    ticks(10);
    snap();
    readCheck(3'd3, 8'h01, "R6 year 00 feb 29 ends");
    readCheck(3'd4, 8'h03, "R6 year 00 month");
    setAll(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h21, 8'h00);
    ticks(10);
    snap();
    readCheck(3'd3, 8'h01, "R6 april ends at 30");
    readCheck(3'd4, 8'h05, "R6 may follows");
    setAll(8'h59, 8'h59, 8'hA3, 8'h30, 8'h08, 8'h21, 8'h00);
    ticks(10);
    snap();
    readCheck(3'd3, 8'h31, "R6 august has 31");

    // R12 unused bits read zero
    writeReg(3'd2, 8'hFF);
    writeReg(3'd6, 8'hFD);
    writeReg(3'd4, 8'hE9);
    endXfer();
    snap();
    readCheck(3'd2, 8'hBF, "R12 hour mask");
    readCheck(3'd6, 8'h05, "R12 dow mask");
    readCheck(3'd4, 8'h09, "R12 month mask");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule